// File: doc/BRIEF.md
# Dual-Interface Power Mode Arbiter

This block chooses which of two input interfaces that share one output path, an analog video input or a digital video link, is the active one, and drives the power-enable lines for the circuit groups behind them. It takes the activity flags from the detectors (horizontal sync, vertical sync and sync-on-green seen on the analog side, link clock seen and data-enable lock on the digital side), together with three control bits: a power-down command, an override enable and an override select. The control bits arrive as plain inputs. No register storage or bus access is part of the block.

The decision follows a fixed priority. A power-down command wins over everything and turns every enable off at the next clock edge. Next comes the manual override, which names the interface directly. Last comes automatic selection from the activity flags, with a tie-break parameter for the case where both interfaces show activity. When neither interface is active, both cores are switched off. The detectors, the bandgap and the link-clock detector stay powered so that activity can wake the chip again. Apart from a power-down, every change of mode waits until the new request has been stable for a set number of cycles, so that flickering detector flags do not make the supplies chatter. All enables come from registers and reset to the all-off state.

Top module: `pwr_mode_arbiter`

## Requirements
- R1: The analog interface counts as active when any of `hsync_seen_i`, `vsync_seen_i` or `sog_seen_i` is 1. The digital interface counts as active only when `lclk_seen_i` and `de_locked_i` are both 1.
- R2: `ana_core_en_o` and `dig_core_en_o` are never 1 in the same cycle.
- R3: With `ovr_en_i` at 1 and no power-down, `ovr_sel_i` picks the interface (0 analog, 1 digital), whatever the activity flags show.
- R4: With `pd_cmd_i` at 1 at a clock edge, `mode_o` becomes 0 (power-down) and every enable output becomes 0 at that same edge, with no settling delay and regardless of the override bits.
- R5: In automatic mode with no activity on either interface, `mode_o` settles to 1 (idle). Both core enables are then 0, while `sync_det_en_o`, `bandgap_en_o` and `lclk_det_en_o` are 1.
- R6: In automatic mode with both interfaces active, analog is chosen when `ANALOG_PRIORITY` is 1 and digital when it is 0.
- R7: In digital mode (`mode_o` = 3), `dig_core_en_o`, `bandgap_en_o`, `sync_det_en_o` and `lclk_det_en_o` are 1, and `ana_core_en_o` is 0.
- R8: In analog mode (`mode_o` = 2), `ana_core_en_o`, `lclk_det_en_o`, `sync_det_en_o` and `bandgap_en_o` are 1, and `dig_core_en_o` is 0.
- R9: A move to a mode other than power-down is committed at the clock edge at which the same requested mode has been seen at `SETTLE_CYCLES` consecutive edges. Until then, `mode_o` and the enables keep their old values.
- R10: During reset, `mode_o` is 0 and every enable output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync_seen_i | input | 1 | Horizontal sync activity flag |
| vsync_seen_i | input | 1 | Vertical sync activity flag |
| sog_seen_i | input | 1 | Sync-on-green activity flag |
| lclk_seen_i | input | 1 | Digital link clock present |
| de_locked_i | input | 1 | Data-enable run found on the digital link |
| pd_cmd_i | input | 1 | Power-down command, highest priority |
| ovr_en_i | input | 1 | 1: manual selection overrides automatic |
| ovr_sel_i | input | 1 | Manual choice: 0 analog, 1 digital |
| mode_o | output | 2 | Committed mode: 0 power-down, 1 idle, 2 analog, 3 digital |
| ana_core_en_o | output | 1 | Analog core power enable |
| dig_core_en_o | output | 1 | Digital core power enable |
| sync_det_en_o | output | 1 | Analog sync detector power enable |
| bandgap_en_o | output | 1 | Bandgap reference power enable |
| lclk_det_en_o | output | 1 | Link-clock detector power enable |

## Verification
The bench builds two copies of the block that share the same stimulus. One uses `SETTLE_CYCLES` = 4 with analog priority. At this setting, requests that flicker for fewer cycles than the settle window are seen to be dropped, and the commit on exactly the fourth stable edge can be observed. The other uses `SETTLE_CYCLES` = 1 with digital priority. This brings the opposite tie-break into reach and shows that a one-cycle window commits at the first edge. Running the two side by side gives both polarities of the tie-break parameter under the same random sequences of activity, override and power-down.

// File: rtl/pma_pkg.sv
// Package: shared types for the dual-interface power mode arbiter.
// Assumes: mode codes are visible on the top-level port and must stay stable.
package pma_pkg;

    // Committed and requested modes; the codes appear on mode_o.
    typedef enum logic [1:0] {
        MODE_PD   = 2'd0,
        MODE_IDLE = 2'd1,
        MODE_ANA  = 2'd2,
        MODE_DIG  = 2'd3
    } mode_t;

    // One enable per power domain.
    typedef struct packed {
        logic ana_core;
        logic dig_core;
        logic sync_det;
        logic bandgap;
        logic lclk_det;
    } pwr_en_t;

    // Map a mode onto the set of domains that must be powered in it.
    function automatic pwr_en_t mode_to_en(input mode_t m);
        pwr_en_t e;
        e = '0;
        unique case (m)
            MODE_PD: begin
                e = '0;
            end
            MODE_IDLE: begin
                e.sync_det = 1'b1;
                e.bandgap  = 1'b1;
                e.lclk_det = 1'b1;
            end
            MODE_ANA: begin
                e.ana_core = 1'b1;
                e.sync_det = 1'b1;
                e.bandgap  = 1'b1;
                e.lclk_det = 1'b1;
            end
            MODE_DIG: begin
                e.dig_core = 1'b1;
                e.sync_det = 1'b1;
                e.bandgap  = 1'b1;
                e.lclk_det = 1'b1;
            end
            default: e = '0;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/pma_activity.sv
// Module: pma_activity
// Combines the raw detector flags into one activity bit per interface.
// Assumes: the flags are already synchronous to clk and filtered upstream.
module pma_activity #(
    parameter int N_SYNC = 3,
    parameter int N_LINK = 2
) (
    input  logic [N_SYNC-1:0] sync_seen_i,
    input  logic [N_LINK-1:0] link_stage_i,
    output logic              ana_act_o,
    output logic              dig_act_o
);

    // Analog side: any sync source present is enough.
    always_comb begin
        ana_act_o = |sync_seen_i;
    end

    // Digital side: every detection stage must have passed.
    always_comb begin
        dig_act_o = &link_stage_i;
    end

endmodule

// File: rtl/pma_select.sv
// Module: pma_select
// Applies the fixed priority: power-down, then manual override, then automatic.
// Assumes: ANALOG_PRIORITY is fixed at build time; it only resolves the case
// where both interfaces are active in automatic mode.
module pma_select
    import pma_pkg::*;
#(
    parameter bit ANALOG_PRIORITY = 1'b1
) (
    input  logic  pd_cmd_i,
    input  logic  ovr_en_i,
    input  logic  ovr_sel_i,
    input  logic  ana_act_i,
    input  logic  dig_act_i,
    output mode_t req_o
);

    mode_t tie_mode;

    // Pick the tie-break winner from the build parameter.
    generate
        if (ANALOG_PRIORITY) begin : g_tie_ana
            assign tie_mode = MODE_ANA;
        end else begin : g_tie_dig
            assign tie_mode = MODE_DIG;
        end
    endgenerate

    // Resolve the requested mode by priority level.
    always_comb begin
        if (pd_cmd_i) begin
            req_o = MODE_PD;
        end else if (ovr_en_i) begin
            req_o = ovr_sel_i ? MODE_DIG : MODE_ANA;
        end else if (ana_act_i && dig_act_i) begin
            req_o = tie_mode;
        end else if (ana_act_i) begin
            req_o = MODE_ANA;
        end else if (dig_act_i) begin
            req_o = MODE_DIG;
        end else begin
            req_o = MODE_IDLE;
        end
    end

endmodule

// File: rtl/pma_settle.sv
// Module: pma_settle
// Filters mode requests: a request must be seen at SETTLE_CYCLES consecutive
// edges before it is committed. A power-down request bypasses the filter.
// Assumes: SETTLE_CYCLES >= 1; the run counter saturates at SETTLE_CYCLES.
module pma_settle
    import pma_pkg::*;
#(
    parameter int SETTLE_CYCLES = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  mode_t req_i,
    output mode_t mode_nx_o,
    output mode_t mode_q_o
);

    localparam int CNT_W = (SETTLE_CYCLES < 1) ? 1 : $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(SETTLE_CYCLES);
    localparam logic [CNT_W-1:0] RUN_ONE = CNT_W'(1);

    mode_t            cand_q;
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] run_nx;
    mode_t            mode_q;

    // Length of the current run of identical requests, including this edge.
    always_comb begin
        if (req_i != cand_q) begin
            run_nx = RUN_ONE;
        end else if (run_q >= RUN_MAX) begin
            run_nx = RUN_MAX;
        end else begin
            run_nx = run_q + RUN_ONE;
        end
    end

    // Next committed mode: power-down at once, others after a full run.
    always_comb begin
        if (req_i == MODE_PD) begin
            mode_nx_o = MODE_PD;
        end else if (run_nx >= RUN_MAX) begin
            mode_nx_o = req_i;
        end else begin
            mode_nx_o = mode_q;
        end
    end

    // Hold the candidate, its run length and the committed mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q <= MODE_PD;
            run_q  <= '0;
            mode_q <= MODE_PD;
        end else begin
            cand_q <= req_i;
            run_q  <= run_nx;
            mode_q <= mode_nx_o;
        end
    end

    assign mode_q_o = mode_q;

endmodule

// File: rtl/pma_power_map.sv
// Module: pma_power_map
// Registers the power enables decoded from the next committed mode, so the
// enables change at the same edge as the mode.
// Assumes: reset state is all domains off.
module pma_power_map
    import pma_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  mode_t   mode_nx_i,
    output pwr_en_t en_o
);

    // Register the decoded enables; reset drops every domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o <= '0;
        end else begin
            en_o <= mode_to_en(mode_nx_i);
        end
    end

endmodule

// File: rtl/pwr_mode_arbiter.sv
// Module: pwr_mode_arbiter (top)
// Chooses the active interface of a dual analog/digital input and drives the
// power enables of its domains. Priority: power-down, override, automatic.
// Assumes: all inputs are synchronous to clk; control bits come from
// registers held elsewhere.
module pwr_mode_arbiter
    import pma_pkg::*;
#(
    parameter int SETTLE_CYCLES   = 4,
    parameter bit ANALOG_PRIORITY = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hsync_seen_i,
    input  logic       vsync_seen_i,
    input  logic       sog_seen_i,
    input  logic       lclk_seen_i,
    input  logic       de_locked_i,
    input  logic       pd_cmd_i,
    input  logic       ovr_en_i,
    input  logic       ovr_sel_i,
    output logic [1:0] mode_o,
    output logic       ana_core_en_o,
    output logic       dig_core_en_o,
    output logic       sync_det_en_o,
    output logic       bandgap_en_o,
    output logic       lclk_det_en_o
);

    logic    ana_act;
    logic    dig_act;
    mode_t   req;
    mode_t   mode_nx;
    mode_t   mode_q;
    pwr_en_t en;

    pma_activity #(
        .N_SYNC (3),
        .N_LINK (2)
    ) u_activity (
        .sync_seen_i  ({hsync_seen_i, vsync_seen_i, sog_seen_i}),
        .link_stage_i ({lclk_seen_i, de_locked_i}),
        .ana_act_o    (ana_act),
        .dig_act_o    (dig_act)
    );

    pma_select #(
        .ANALOG_PRIORITY (ANALOG_PRIORITY)
    ) u_select (
        .pd_cmd_i  (pd_cmd_i),
        .ovr_en_i  (ovr_en_i),
        .ovr_sel_i (ovr_sel_i),
        .ana_act_i (ana_act),
        .dig_act_i (dig_act),
        .req_o     (req)
    );

    pma_settle #(
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_settle (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req),
        .mode_nx_o (mode_nx),
        .mode_q_o  (mode_q)
    );

    pma_power_map u_power_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_nx_i (mode_nx),
        .en_o      (en)
    );

    assign mode_o        = mode_q;
    assign ana_core_en_o = en.ana_core;
    assign dig_core_en_o = en.dig_core;
    assign sync_det_en_o = en.sync_det;
    assign bandgap_en_o  = en.bandgap;
    assign lclk_det_en_o = en.lclk_det;

endmodule

// File: rtl/pma_checker.sv
// Module: pma_checker
// Concurrent checks on the arbiter's ports, attached by bind.
// Assumes: synchronous active-low reset on rst_n.
module pma_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       pd_cmd_i,
    input logic [1:0] mode_o,
    input logic       ana_core_en_o,
    input logic       dig_core_en_o,
    input logic       sync_det_en_o,
    input logic       bandgap_en_o,
    input logic       lclk_det_en_o
);

    // R2: the two cores are never powered together.
    p_one_core_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(ana_core_en_o && dig_core_en_o));

    // R4: a power-down command clears every enable at the next sample.
    p_pd_all_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pd_cmd_i |=> (mode_o == 2'd0 && !ana_core_en_o && !dig_core_en_o &&
                      !sync_det_en_o && !bandgap_en_o && !lclk_det_en_o));

    // R4: no core may power up at an edge where power-down was requested.
    p_no_wake_in_pd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dig_core_en_o) |-> !$past(pd_cmd_i));

    // R7: the digital core never runs without bandgap and sync detectors.
    p_dig_keeps_det_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dig_core_en_o |-> (bandgap_en_o && sync_det_en_o));

    // R8: the analog core never runs without the link-clock detector.
    p_ana_keeps_lclk_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ana_core_en_o |-> lclk_det_en_o);

    // R10: leaving reset, the block shows the all-off state.
    p_reset_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mode_o == 2'd0 && !ana_core_en_o && !dig_core_en_o &&
                          !sync_det_en_o && !bandgap_en_o && !lclk_det_en_o));

endmodule

bind pwr_mode_arbiter pma_checker u_pma_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .pd_cmd_i      (pd_cmd_i),
    .mode_o        (mode_o),
    .ana_core_en_o (ana_core_en_o),
    .dig_core_en_o (dig_core_en_o),
    .sync_det_en_o (sync_det_en_o),
    .bandgap_en_o  (bandgap_en_o),
    .lclk_det_en_o (lclk_det_en_o)
);

// File: tb/pwr_mode_arbiter_tb_top.sv
// Bench: two arbiter copies (settle 4 / analog priority, settle 1 / digital
// priority) driven with the same stimulus and compared with a bench model.
module pwr_mode_arbiter_tb_top;

    localparam int S_A = 4;
    localparam int S_B = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs = 0, vs = 0, sog = 0, lc = 0, de = 0, pd = 0, oe = 0, os = 0;

    logic [1:0] mode_a, mode_b;
    logic [4:0] en_a, en_b;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Model state per copy: index 0 = dut_i, 1 = dut_b_i.
    int m_cand [2];
    int m_run  [2];
    int m_mode [2];
    int m_prev [2];
    int m_set  [2];
    bit m_apri [2];

    always #5 clk = ~clk;

    pwr_mode_arbiter #(.SETTLE_CYCLES(S_A), .ANALOG_PRIORITY(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .hsync_seen_i(hs), .vsync_seen_i(vs),
        .sog_seen_i(sog), .lclk_seen_i(lc), .de_locked_i(de), .pd_cmd_i(pd),
        .ovr_en_i(oe), .ovr_sel_i(os), .mode_o(mode_a),
        .ana_core_en_o(en_a[4]), .dig_core_en_o(en_a[3]), .sync_det_en_o(en_a[2]),
        .bandgap_en_o(en_a[1]), .lclk_det_en_o(en_a[0]));

    pwr_mode_arbiter #(.SETTLE_CYCLES(S_B), .ANALOG_PRIORITY(1'b0)) dut_b_i (
        .clk(clk), .rst_n(rst_n), .hsync_seen_i(hs), .vsync_seen_i(vs),
        .sog_seen_i(sog), .lclk_seen_i(lc), .de_locked_i(de), .pd_cmd_i(pd),
        .ovr_en_i(oe), .ovr_sel_i(os), .mode_o(mode_b),
        .ana_core_en_o(en_b[4]), .dig_core_en_o(en_b[3]), .sync_det_en_o(en_b[2]),
        .bandgap_en_o(en_b[1]), .lclk_det_en_o(en_b[0]));

    // Requested mode from the priority rules (R1, R3, R4, R5, R6).
    function automatic int req_f(input bit apri);
        bit a, d;
        a = hs | vs | sog;
        d = lc & de;
        if (pd) return 0;
        if (oe) return os ? 3 : 2;
        if (a && d) return apri ? 2 : 3;
        if (a) return 2;
        if (d) return 3;
        return 1;
    endfunction

    // Expected enables {ana, dig, sync, bandgap, lclk} per mode (R5, R7, R8).
    function automatic logic [4:0] en_f(input int m);
        case (m)
            1: return 5'b00111;
            2: return 5'b10111;
            3: return 5'b01111;
            default: return 5'b00000;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            m_cand[k] = 0; m_run[k] = 0; m_mode[k] = 0; m_prev[k] = 0;
        end
    endtask

    // Advance one edge, update the model, compare both copies.
    task automatic run_cycle(input string tag);
        @(posedge clk);
        #1;
        for (int k = 0; k < 2; k++) begin
            int r, run;
            string t;
            r = req_f(m_apri[k]);
            run = (r == m_cand[k]) ? ((m_run[k] >= m_set[k]) ? m_set[k] : m_run[k] + 1) : 1;
            m_cand[k] = r;
            m_run[k] = run;
            m_prev[k] = m_mode[k];
            if (r == 0) m_mode[k] = 0;
            else if (run >= m_set[k]) m_mode[k] = r;
            if (tag != "") t = tag;
            else if (pd) t = "R4";
            else if (m_cand[k] != m_mode[k] || m_prev[k] != m_mode[k]) t = "R9";
            else if (m_mode[k] == 1) t = "R5";
            else if (m_mode[k] == 2) t = "R8";
            else t = "R7";
            if (k == 0) begin
                chk(mode_a == 2'(m_mode[0]), t, "dut_i mode", int'(mode_a), m_mode[0]);
                chk(en_a == en_f(m_mode[0]), t, "dut_i enables", int'(en_a), int'(en_f(m_mode[0])));
                chk(!(en_a[4] && en_a[3]), "R2", "dut_i both cores", int'(en_a), 0);
            end else begin
                chk(mode_b == 2'(m_mode[1]), t, "dut_b_i mode", int'(mode_b), m_mode[1]);
                chk(en_b == en_f(m_mode[1]), t, "dut_b_i enables", int'(en_b), int'(en_f(m_mode[1])));
                chk(!(en_b[4] && en_b[3]), "R2", "dut_b_i both cores", int'(en_b), 0);
            end
        end
    endtask

    task automatic set_in(input bit h, v, s, l, d, p, e, o);
        hs = h; vs = v; sog = s; lc = l; de = d; pd = p; oe = e; os = o;
    endtask

    task automatic hold(input int n, input string tag);
        for (int i = 0; i < n; i++) run_cycle(tag);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unused;
        unused = $urandom(32'd7351);
        m_set[0] = S_A; m_apri[0] = 1'b1;
        m_set[1] = S_B; m_apri[1] = 1'b0;
        model_reset();

        // R10: reset state, held in reset with activity present.
        set_in(1, 1, 1, 1, 1, 0, 0, 0);
        repeat (3) @(posedge clk);
        #1;
        chk(mode_a == 2'd0 && en_a == 5'b0, "R10", "dut_i reset", int'({mode_a, en_a}), 0);
        chk(mode_b == 2'd0 && en_b == 5'b0, "R10", "dut_b_i reset", int'({mode_b, en_b}), 0);
        rst_n = 1'b1;

        // R6: both active, tie-break differs between the two copies.
        hold(5, "R6");
        // R1: analog from sync-on-green alone; settle window observed (R9).
        set_in(0, 0, 1, 0, 0, 0, 0, 0);
        hold(S_A - 1, "R9");
        hold(2, "R1");
        // R1: link clock without DE lock is not digital activity.
        set_in(0, 0, 0, 1, 0, 0, 0, 0);
        hold(5, "R1");
        // R1: both digital stages present gives digital mode.
        set_in(0, 0, 0, 1, 1, 0, 0, 0);
        hold(5, "R1");
        // R9: flicker shorter than the window leaves mode unchanged.
        set_in(1, 0, 0, 0, 0, 0, 0, 0);
        hold(2, "R9");
        set_in(0, 0, 0, 1, 1, 0, 0, 0);
        hold(3, "R9");
        // R3: override to analog with no activity, then to digital.
        set_in(0, 0, 0, 0, 0, 0, 1, 0);
        hold(5, "R3");
        set_in(1, 1, 1, 0, 0, 0, 1, 1);
        hold(5, "R3");
        // R4: power-down beats override in one edge.
        set_in(1, 1, 1, 1, 1, 1, 1, 1);
        hold(2, "R4");
        // R5: no activity in automatic mode gives idle.
        set_in(0, 0, 0, 0, 0, 0, 0, 0);
        hold(6, "R5");

        // Random phase with held stimulus.
        for (int n = 0; n < 600; n++) begin
            bit [7:0] r;
            r = 8'($urandom);
            set_in(r[0], r[1] & r[2], r[3] & r[4], r[5], r[6] | r[5],
                   ($urandom % 12) == 0, ($urandom % 4) == 0, r[7]);
            hold(1 + int'($urandom % 6), "");
        end

        // Mid-run reset returns to the all-off state (R10).
        set_in(1, 0, 0, 0, 0, 0, 0, 0);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        model_reset();
        chk(mode_a == 2'd0 && en_a == 5'b0, "R10", "dut_i mid reset", int'({mode_a, en_a}), 0);
        chk(mode_b == 2'd0 && en_b == 5'b0, "R10", "dut_b_i mid reset", int'({mode_b, en_b}), 0);
        rst_n = 1'b1;
        hold(6, "R8");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule